// File: doc/BRIEF.md
# Flash Window Range Guard

This block sits in the path where processor loads and stores to the memory-mapped flash window become serial flash transactions. Every request arriving on the access port is compared, in the same cycle, against four programmable protected ranges. A range that covers the address and forbids that kind of access stops the transfer. A stopped read hands the processor all-ones data. A stopped write is dropped. Either kind of stop raises a sticky violation flag, and software clears it by writing 1.

The ranges are programmed through a small configuration port. Each range register takes one write after reset and ignores every later write. A separate control word carries two enable bits and a lock bit. Once lock is set, the enables are frozen until reset. The guard judges only direct window accesses. Register-driven command traffic to the flash controller does not pass through it.

Top module: `flash_range_guard`

## Requirements
- R1: After reset, no range is programmed, both enables and the lock are clear, and the violation flag is 0. Every access is granted.
- R2: Each range register accepts the first configuration write after reset. Any later write to that register is ignored.
- R3: Range fields in the configuration word:
  - base page: bits 11:0
  - size in pages: bits 23:12
  - read-protect: bit 24
  - write-protect: bit 25

  Pages are 4 KiB and the page number is address bits 23:12. An address matches when base ≤ page < base + size. A size of zero never matches.
- R4: Enable bit 0 of the control word activates ranges 0 and 1. Enable bit 1 activates ranges 2 and 3. A range that is not active never blocks.
- R5: Read-protect blocks reads only, and write-protect blocks writes only. The decision is combinational: `blocked` and `grant` follow the request in the same cycle, and `grant` = valid and not blocked.
- R6: When ranges overlap, an access is blocked if any active range containing the address forbids it.
- R7: Control word fields:
  - bit 0: enable 0
  - bit 1: enable 1
  - bit 2: lock

  A control write while lock is clear loads all three bits. Once lock is set, control writes are ignored until reset.
- R8: A blocked read returns all-ones on `cpu_rdata`. Otherwise `cpu_rdata` equals `fl_rdata`.
- R9: A blocked access sets `viol_flag` from the next cycle on. The flag holds until a write of 1 to bit 0 at the clear selector. When a clear and a blocked access fall in the same cycle, the flag stays set.
- R10: Only addresses 0xFF000000 to 0xFFFFFFFF are checked. Any other address is never blocked.

Configuration selectors on `cfg_sel`:
- 0 to 3: range registers 0 to 3
- 4: control word
- 5: violation clear

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration selector (0-3 ranges, 4 control, 5 clear) |
| cfg_wdata | input | 26 | Configuration write data |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 32 | Byte address of the access |
| fl_rdata | input | 32 | Read data coming back from flash |
| grant | output | 1 | Access may proceed |
| blocked | output | 1 | Access is stopped by a protected range |
| cpu_rdata | output | 32 | Read data returned to the processor |
| viol_flag | output | 1 | Sticky violation indication |

## Verification
Clearing the violation flag and raising a new violation can fall in the same cycle. The bench provokes this by issuing a clear write at the same time as a read into a read-protected range. The flag must still read 1 one cycle later, and it must drop only after a clear with no blocked access beside it.

The bench also lands a control write on the same cycle as the lock being set, and checks that the enables written with the lock stick while later writes have no effect.

A behavioural reference model in the bench predicts `grant`, `blocked`, `cpu_rdata` and `viol_flag` on every clock.

// File: rtl/frg_pkg.sv
package frg_pkg;

    localparam int N_RANGE   = 4;
    localparam int N_ENABLE  = 2;
    localparam int PER_EN    = N_RANGE / N_ENABLE;
    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int PAGE_W    = 12;
    localparam int OFS_W     = 12;
    localparam int TAG_W     = ADDR_W - PAGE_W - OFS_W;
    localparam int CFG_W     = 2 * PAGE_W + 2;
    localparam logic [TAG_W-1:0] WIN_TAG = '1;

    typedef enum logic [2:0] {
        SEL_RNG0 = 3'd0,
        SEL_RNG1 = 3'd1,
        SEL_RNG2 = 3'd2,
        SEL_RNG3 = 3'd3,
        SEL_CTRL = 3'd4,
        SEL_VCLR = 3'd5
    } cfg_sel_e;

    typedef struct packed {
        logic              wr_prot;
        logic              rd_prot;
        logic [PAGE_W-1:0] size;
        logic [PAGE_W-1:0] base;
    } range_t;

    function automatic range_t word_to_range(input logic [CFG_W-1:0] w);
        range_t r;
        r.base    = w[PAGE_W-1:0];
        r.size    = w[2*PAGE_W-1:PAGE_W];
        r.rd_prot = w[2*PAGE_W];
        r.wr_prot = w[2*PAGE_W+1];
        return r;
    endfunction

    function automatic logic page_hit(input range_t r, input logic [PAGE_W-1:0] pg);
        logic [PAGE_W:0] lim;
        lim = {1'b0, r.base} + {1'b0, r.size};
        return (r.size != '0) && (pg >= r.base) && ({1'b0, pg} < lim);
    endfunction

endpackage

// File: rtl/frg_bank.sv
module frg_bank
    import frg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [2:0]              cfg_sel,
    input  logic [CFG_W-1:0]        cfg_wdata,
    output range_t [N_RANGE-1:0]    rng_q
);

    logic [N_RANGE-1:0] taken_q;

    for (genvar g = 0; g < N_RANGE; g++) begin : g_rng
        // R2: one accepted write per register after reset
        always_ff @(posedge clk) begin
            if (rst) begin
                rng_q[g]   <= '0;
                taken_q[g] <= 1'b0;
            end else if (cfg_we && (cfg_sel == 3'(g)) && !taken_q[g]) begin
                rng_q[g]   <= word_to_range(cfg_wdata);
                taken_q[g] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/frg_ctrl.sv
module frg_ctrl
    import frg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [2:0]          cfg_sel,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic                viol_set,
    output logic [N_ENABLE-1:0] en_q,
    output logic                lock_q,
    output logic                viol_q
);

    logic ctrl_wr;
    logic clr_wr;

    assign ctrl_wr = cfg_we && (cfg_sel == SEL_CTRL) && !lock_q;
    assign clr_wr  = cfg_we && (cfg_sel == SEL_VCLR) && cfg_wdata[0];

    // R7: enables and lock load together, frozen once lock is set
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            lock_q <= 1'b0;
        end else if (ctrl_wr) begin
            en_q   <= cfg_wdata[N_ENABLE-1:0];
            lock_q <= cfg_wdata[N_ENABLE];
        end
    end

    // R9: set has priority over clear
    always_ff @(posedge clk) begin
        if (rst)           viol_q <= 1'b0;
        else if (viol_set) viol_q <= 1'b1;
        else if (clr_wr)   viol_q <= 1'b0;
    end

endmodule

// File: rtl/frg_match.sv
module frg_match
    import frg_pkg::*;
(
    input  range_t              rng,
    input  logic                active,
    input  logic                in_win,
    input  logic                is_wr,
    input  logic [PAGE_W-1:0]   page,
    output logic                deny
);

    logic forbid;

    // R5: protection bit picked by access kind
    assign forbid = is_wr ? rng.wr_prot : rng.rd_prot;

    // R3 R4 R10
    assign deny = active && in_win && forbid && page_hit(rng, page);

endmodule

// File: rtl/flash_range_guard.sv
module flash_range_guard
    import frg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [2:0]          cfg_sel,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   fl_rdata,
    output logic                grant,
    output logic                blocked,
    output logic [DATA_W-1:0]   cpu_rdata,
    output logic                viol_flag
);

    range_t [N_RANGE-1:0] rng_q;
    logic [N_ENABLE-1:0]  en_q;
    logic                 lock_q;
    logic [N_RANGE-1:0]   deny_vec;
    logic                 in_win;
    logic [PAGE_W-1:0]    page;

    assign in_win = (req_addr[ADDR_W-1 -: TAG_W] == WIN_TAG);
    assign page   = req_addr[OFS_W +: PAGE_W];

    frg_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .rng_q     (rng_q)
    );

    frg_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .viol_set  (blocked),
        .en_q      (en_q),
        .lock_q    (lock_q),
        .viol_q    (viol_flag)
    );

    for (genvar g = 0; g < N_RANGE; g++) begin : g_chk
        frg_match u_match (
            .rng    (rng_q[g]),
            .active (en_q[g / PER_EN]),
            .in_win (in_win),
            .is_wr  (req_write),
            .page   (page),
            .deny   (deny_vec[g])
        );
    end

    // R6: any forbidding active range wins
    assign blocked   = req_valid && (|deny_vec);
    assign grant     = req_valid && !blocked;
    // R8
    assign cpu_rdata = (blocked && !req_write) ? '1 : fl_rdata;

endmodule

// File: rtl/frg_checker.sv
module frg_checker
    import frg_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                cfg_we,
    input logic [2:0]          cfg_sel,
    input logic [CFG_W-1:0]    cfg_wdata,
    input logic                req_valid,
    input logic                req_write,
    input logic [ADDR_W-1:0]   req_addr,
    input logic [DATA_W-1:0]   fl_rdata,
    input logic                blocked,
    input logic                grant,
    input logic [DATA_W-1:0]   cpu_rdata,
    input logic                viol_flag,
    input logic                lock_q,
    input logic [N_ENABLE-1:0] en_q
);

    // R9
    viol_set_chk: assert property (@(posedge clk) disable iff (rst)
        blocked |=> viol_flag);

    // R9
    viol_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (viol_flag && !(cfg_we && cfg_sel == SEL_VCLR && cfg_wdata[0])) |=> viol_flag);

    // R10
    outside_win_chk: assert property (@(posedge clk) disable iff (rst)
        (req_addr[ADDR_W-1 -: TAG_W] != WIN_TAG) |-> !blocked);

    // R8
    rdata_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (grant && !req_write) |-> (cpu_rdata == fl_rdata));

    // R7
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> (lock_q && $stable(en_q)));

    // R5
    grant_kind_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!grant && !blocked));

endmodule

bind flash_range_guard frg_checker u_frg_checker (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .fl_rdata  (fl_rdata),
    .blocked   (blocked),
    .grant     (grant),
    .cpu_rdata (cpu_rdata),
    .viol_flag (viol_flag),
    .lock_q    (lock_q),
    .en_q      (en_q)
);

// File: tb/flash_range_guard_bench.sv
module flash_range_guard_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [2:0]  cfg_sel;
    logic [25:0] cfg_wdata;
    logic        req_valid;
    logic        req_write;
    logic [31:0] req_addr;
    logic [31:0] fl_rdata;
    logic        grant;
    logic        blocked;
    logic [31:0] cpu_rdata;
    logic        viol_flag;

    int    checks = 0;
    int    errors = 0;
    string phase  = "R1";
    bit    done   = 0;

    // behavioural model state
    int m_base [4];
    int m_size [4];
    bit m_rp [4];
    bit m_wp [4];
    bit m_used [4];
    bit m_en [2];
    bit m_lock;
    bit m_viol;

    always #4 clk = ~clk;

    flash_range_guard u_flash_range_guard (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .fl_rdata  (fl_rdata),
        .grant     (grant),
        .blocked   (blocked),
        .cpu_rdata (cpu_rdata),
        .viol_flag (viol_flag)
    );

    function automatic bit model_block();
        int pg;
        bit b = 0;
        if (!req_valid || req_addr[31:24] != 8'hFF) return 0;
        pg = int'(req_addr[23:12]);
        for (int i = 0; i < 4; i++) begin
            if (m_en[i / 2] && m_size[i] != 0 && pg >= m_base[i]
                && pg < m_base[i] + m_size[i]
                && (req_write ? m_wp[i] : m_rp[i]))
                b = 1;
        end
        return b;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) begin
                m_base[i] = 0; m_size[i] = 0; m_rp[i] = 0; m_wp[i] = 0; m_used[i] = 0;
            end
            m_en[0] = 0; m_en[1] = 0; m_lock = 0; m_viol = 0;
        end else begin
            bit blk;
            blk = model_block();
            if (blk) m_viol = 1;
            else if (cfg_we && cfg_sel == 3'd5 && cfg_wdata[0]) m_viol = 0;
            if (cfg_we && cfg_sel < 3'd4 && !m_used[cfg_sel]) begin
                m_base[cfg_sel] = int'(cfg_wdata[11:0]);
                m_size[cfg_sel] = int'(cfg_wdata[23:12]);
                m_rp[cfg_sel]   = cfg_wdata[24];
                m_wp[cfg_sel]   = cfg_wdata[25];
                m_used[cfg_sel] = 1;
            end
            if (cfg_we && cfg_sel == 3'd4 && !m_lock) begin
                m_en[0] = cfg_wdata[0];
                m_en[1] = cfg_wdata[1];
                m_lock  = cfg_wdata[2];
            end
        end
    end

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (!rst && !done) begin
                bit b;
                b = model_block();
                check(phase, "blocked", 32'(blocked), 32'(b));
                check(phase, "grant", 32'(grant), 32'(req_valid && !b));
                check(phase == "R9" ? "R9" : "R1", "viol_flag", 32'(viol_flag), 32'(m_viol));
                check(phase == "R8" ? "R8" : "R5", "cpu_rdata", cpu_rdata,
                      (b && !req_write) ? 32'hFFFF_FFFF : fl_rdata);
            end
        end
    end

    task automatic step(input bit we, input logic [2:0] sel, input logic [25:0] wd,
                        input bit rv, input bit rw, input logic [31:0] a);
        @(negedge clk);
        cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
        req_valid = rv; req_write = rw; req_addr = a;
        fl_rdata = a ^ 32'h5A5A_C3C3;
    endtask

    task automatic cfg(input logic [2:0] sel, input logic [25:0] wd);
        step(1, sel, wd, 0, 0, 32'h0);
    endtask

    task automatic acc(input bit rw, input logic [31:0] a);
        step(0, 3'd0, 26'h0, 1, rw, a);
    endtask

    function automatic logic [25:0] rword(input int base, input int size, input bit rp, input bit wp);
        return {wp, rp, 12'(size), 12'(base)};
    endfunction

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
        req_valid = 0; req_write = 0; req_addr = 0; fl_rdata = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state, everything granted
        phase = "R1";
        acc(0, 32'hFF01_0000); acc(1, 32'hFFFF_F000); acc(1, 32'hFF00_0000);
        #3 check("R1", "viol after reset", 32'(viol_flag), 32'h0);

        // R3 R5: range0 write-protected pages 0x010..0x013
        phase = "R3";
        cfg(3'd0, rword(12'h010, 4, 0, 1));
        cfg(3'd4, 26'h1);
        acc(1, 32'hFF00_F000); acc(1, 32'hFF01_0000); acc(1, 32'hFF01_3FFC);
        acc(1, 32'hFF01_4000);
        phase = "R5";
        acc(0, 32'hFF01_0000); acc(1, 32'hFF01_2000);
        #3 check("R5", "write into protected page", 32'(blocked), 32'h1);

        // R2: rewrite ignored
        phase = "R2";
        cfg(3'd0, rword(0, 0, 0, 0));
        acc(1, 32'hFF01_1000);
        #3 check("R2", "second write ignored", 32'(blocked), 32'h1);

        // R3: size zero never matches
        phase = "R3";
        cfg(3'd1, rword(12'h100, 0, 1, 1));
        acc(1, 32'hFF10_0000); acc(0, 32'hFF10_0000);

        // R4: range2 inactive until enable 1
        phase = "R4";
        cfg(3'd2, rword(12'h200, 16, 1, 0));
        acc(0, 32'hFF20_0000);
        #3 check("R4", "inactive range", 32'(blocked), 32'h0);
        cfg(3'd4, 26'h2);
        acc(0, 32'hFF20_0000); acc(1, 32'hFF01_0000);
        #3 check("R4", "range0 off with enable 0 clear", 32'(blocked), 32'h0);

        // R6: overlap, range3 permits but range2 forbids reads
        phase = "R6";
        cfg(3'd3, rword(12'h205, 2, 0, 0));
        acc(0, 32'hFF20_5000);
        #3 check("R6", "overlap read", 32'(blocked), 32'h1);
        acc(1, 32'hFF20_6000);

        // R10: outside the window
        phase = "R10";
        acc(0, 32'hFE20_0000); acc(0, 32'h0020_0000);
        #3 check("R10", "outside window", 32'(blocked), 32'h0);

        // R8: blocked read data
        phase = "R8";
        acc(0, 32'hFF20_F000);
        #3 check("R8", "blocked rdata", cpu_rdata, 32'hFFFF_FFFF);
        acc(0, 32'hFF21_0000);

        // R9: sticky, clear, and clear colliding with a violation
        phase = "R9";
        step(0, 3'd0, 26'h0, 0, 0, 32'h0);
        #3 check("R9", "flag sticky", 32'(viol_flag), 32'h1);
        cfg(3'd5, 26'h0);
        cfg(3'd5, 26'h1);
        step(0, 3'd0, 26'h0, 0, 0, 32'h0);
        #3 check("R9", "flag cleared", 32'(viol_flag), 32'h0);
        step(1, 3'd5, 26'h1, 1, 0, 32'hFF20_1000);
        step(0, 3'd0, 26'h0, 0, 0, 32'h0);
        #3 check("R9", "set wins over clear", 32'(viol_flag), 32'h1);
        cfg(3'd5, 26'h1);

        // R7: lock freezes enables
        phase = "R7";
        cfg(3'd4, 26'h7);
        cfg(3'd4, 26'h0);
        acc(1, 32'hFF01_0000); acc(0, 32'hFF20_2000);
        #3 check("R7", "enables frozen", 32'(blocked), 32'h1);
        cfg(3'd4, 26'h3);
        acc(0, 32'hFF20_2000);
        step(0, 3'd0, 26'h0, 0, 0, 32'h0);
        step(0, 3'd0, 26'h0, 0, 0, 32'h0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule